// File: doc/BRIEF.md
# Attached RAM Size Detector

This block finds out how much byte-wide RAM sits behind a memory port once the surrounding logic has gained ownership of the bus. On a start pulse it runs a walking-address probe. It saves the bytes at locations 0 and 1. It then checks that location 0 can hold a value at all, by writing the complement of the saved byte and reading it back. Finally it places a marker at location 0 and tests each power-of-two address in turn, looking for the point where the address space wraps onto location 0 or stops answering.

Every location the probe overwrites gets its original contents back. Memory keeps its contents across the test, except for a location that has no storage behind it. The result is a size in bytes, which is always a power of two, or a separate flag saying that no RAM answered. A done level marks the result as valid and stays high until the next start. Arbitration and strobe timing belong to an external controller. This block only issues single transactions on a request/acknowledge port.

Top module: `ramsz_top`

## Requirements
- R1: After `start`, the first three transactions are a read of address 0, a read of address 1, and a write at address 0 of the bitwise complement of the byte read from address 0.
- R2: If the next read of address 0 does not return exactly that complement, the result is `no_ram`=1 with `size`=0, and no probe addresses are visited.
- R3: Otherwise 0x55 is written at address 0, and the probe addresses are 1, 2, 4, ... doubling, each strictly below `MAX_SIZE`.
- R4: At each probe address p the order is: read p, write 0xAA at p, read 0, then read p only when address 0 returned 0x55.
- R5: If address 0 does not read 0x55, or p does not read 0xAA, probing stops with `size`=p and that location is not written back.
- R6: A probe address that passes is written back with the byte read from it, before the next probe address is tried.
- R7: If every probe address passes, `size`=`MAX_SIZE` and `no_ram`=0.
- R8: The run always ends by writing the saved byte of address 1 at address 1, then the saved byte of address 0 at address 0. After that, `done` rises and stays high with the result until the next `start`. In the test memories used here, this leaves every location as it was before the run.
- R9: At most one transaction is open at a time. While `mem_req` is high without `mem_ack`, the request and its address, direction and write data hold. After an acknowledge, `mem_req` is low for at least one cycle.
- R10: A `start` pulse while a run is in progress is ignored.
- R11: While `rst_n` is low and directly after reset: `mem_req`, `done` and `no_ram` are 0 and `size` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a detection run (bus already granted) |
| mem_req | output | 1 | Transaction request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Transaction address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Transaction complete; read data valid in this cycle |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | Result valid, held until next start |
| no_ram | output | 1 | No writable storage at address 0 |
| size | output | AW+1 | Detected size in bytes (0 when no RAM) |

## Verification
The checker watches the port handshake on every cycle. It checks that a request and its fields hold until acknowledged and that there is a gap after each acknowledge. It also checks that addresses stay below the maximum, that `done` is held with the port quiet, and that a reported size is zero with `no_ram` or a single power of two without it. Only the bench scenarios can show the exact order and values of the transactions, the stopping point on a wrap or on an address that does not answer, and that memory returns to its original contents. To do this, a behavioural model runs the same probe against emulated memories: absent, 1 byte, 2 bytes, wrapping, full size, and answering only below a limit. The model compares each acknowledged transaction as it happens.

// File: rtl/ramsz_pkg.sv
// Shared definitions for the RAM size detector.
// Assumes byte-wide memory and a power-of-two probe limit.
package ramsz_pkg;

    // Sequencer steps; each non-idle step except DONE issues one transaction
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_WINV,
        ST_CHKINV,
        ST_WMARK,
        ST_PRD,
        ST_PWR,
        ST_PCHK0,
        ST_PCHKP,
        ST_PRST,
        ST_REST1,
        ST_REST0,
        ST_DONE
    } step_e;

    localparam logic [7:0] MARK_BYTE = 8'h55;
    localparam logic [7:0] ANTI_MARK = 8'hAA;

endpackage

// File: rtl/ramsz_port.sv
// Single-transaction memory port issuer.
// Takes a one-cycle issue pulse with op fields, raises mem_req and holds
// the fields until mem_ack, then returns a one-cycle completion pulse with
// the captured read data. Assumes issue only arrives while idle.
module ramsz_port #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          op_we,
    input  logic [AW-1:0] op_addr,
    input  logic [7:0]    op_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ack,
    input  logic [7:0]    mem_rdata,
    output logic          cpl,
    output logic [7:0]    rdata
);

    // Request register: open on issue, close on acknowledge, capture data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            cpl       <= 1'b0;
            rdata     <= '0;
        end else begin
            cpl <= 1'b0;
            if (issue) begin
                mem_req   <= 1'b1;
                mem_we    <= op_we;
                mem_addr  <= op_addr;
                mem_wdata <= op_wdata;
            end else if (mem_req && mem_ack) begin
                mem_req <= 1'b0;
                cpl     <= 1'b1;
                rdata   <= mem_rdata;
            end
        end
    end

endmodule

// File: rtl/ramsz_seq.sv
// Probe sequencer for the RAM size detector.
// Walks the save / complement / marker / power-of-two probe / restore
// sequence, one transaction per step, and holds the result.
// Assumes MAX_SIZE is a power of two no larger than 2**AW.
module ramsz_seq
    import ramsz_pkg::*;
#(
    parameter int AW       = 20,
    parameter int MAX_SIZE = 1 << 20,
    parameter int SW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cpl,
    input  logic [7:0]    rdata,
    output logic          issue,
    output logic          op_we,
    output logic [AW-1:0] op_addr,
    output logic [7:0]    op_wdata,
    output logic          done,
    output logic          no_ram,
    output logic [SW-1:0] size
);

    localparam logic [SW-1:0] LIMIT = SW'(MAX_SIZE);

    step_e         st;
    logic          wait_q;
    logic [7:0]    sv0, sv1, svp;
    logic [SW-1:0] probe;
    logic          is_op;

    // Decode the transaction belonging to the current step
    always_comb begin
        is_op    = 1'b1;
        op_we    = 1'b0;
        op_addr  = '0;
        op_wdata = '0;
        unique case (st)
            ST_RD0:    ;
            ST_RD1:    op_addr = AW'(1);
            ST_WINV:   begin op_we = 1'b1; op_wdata = ~sv0; end
            ST_CHKINV: ;
            ST_WMARK:  begin op_we = 1'b1; op_wdata = MARK_BYTE; end
            ST_PRD:    op_addr = probe[AW-1:0];
            ST_PWR:    begin op_we = 1'b1; op_addr = probe[AW-1:0]; op_wdata = ANTI_MARK; end
            ST_PCHK0:  ;
            ST_PCHKP:  op_addr = probe[AW-1:0];
            ST_PRST:   begin op_we = 1'b1; op_addr = probe[AW-1:0]; op_wdata = svp; end
            ST_REST1:  begin op_we = 1'b1; op_addr = AW'(1); op_wdata = sv1; end
            ST_REST0:  begin op_we = 1'b1; op_wdata = sv0; end
            default:   is_op = 1'b0;
        endcase
    end

    assign issue = is_op && !wait_q;

    // Step register: advance on each completion and judge read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            wait_q <= 1'b0;
            sv0    <= '0;
            sv1    <= '0;
            svp    <= '0;
            probe  <= '0;
            done   <= 1'b0;
            no_ram <= 1'b0;
            size   <= '0;
        end else if (!is_op) begin
            if (start) begin
                st     <= ST_RD0;
                done   <= 1'b0;
                no_ram <= 1'b0;
                size   <= '0;
            end
        end else if (!wait_q) begin
            wait_q <= 1'b1;
        end else if (cpl) begin
            wait_q <= 1'b0;
            unique case (st)
                ST_RD0: begin sv0 <= rdata; st <= ST_RD1; end
                ST_RD1: begin sv1 <= rdata; st <= ST_WINV; end
                ST_WINV: st <= ST_CHKINV;
                ST_CHKINV: begin
                    if (rdata == ~sv0) st <= ST_WMARK;
                    else begin no_ram <= 1'b1; st <= ST_REST1; end
                end
                ST_WMARK: begin
                    probe <= SW'(1);
                    if (LIMIT <= SW'(1)) begin size <= LIMIT; st <= ST_REST1; end
                    else st <= ST_PRD;
                end
                ST_PRD: begin svp <= rdata; st <= ST_PWR; end
                ST_PWR: st <= ST_PCHK0;
                ST_PCHK0: begin
                    if (rdata == MARK_BYTE) st <= ST_PCHKP;
                    else begin size <= probe; st <= ST_REST1; end
                end
                ST_PCHKP: begin
                    if (rdata == ANTI_MARK) st <= ST_PRST;
                    else begin size <= probe; st <= ST_REST1; end
                end
                ST_PRST: begin
                    if ((probe << 1) >= LIMIT) begin size <= LIMIT; st <= ST_REST1; end
                    else begin probe <= probe << 1; st <= ST_PRD; end
                end
                ST_REST1: st <= ST_REST0;
                ST_REST0: begin done <= 1'b1; st <= ST_DONE; end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ramsz_top.sv
// RAM size detector top level.
// Joins the probe sequencer to the single-transaction port issuer.
// Assumes the bus is already granted when start is pulsed.
module ramsz_top #(
    parameter int AW       = 20,
    parameter int MAX_SIZE = 1 << 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ack,
    input  logic [7:0]    mem_rdata,
    output logic          done,
    output logic          no_ram,
    output logic [AW:0]   size
);

    localparam int SW = AW + 1;

    logic          issue, op_we, cpl;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_wdata, rdata;

    ramsz_seq #(.AW(AW), .MAX_SIZE(MAX_SIZE), .SW(SW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cpl(cpl), .rdata(rdata),
        .issue(issue), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
        .done(done), .no_ram(no_ram), .size(size)
    );

    ramsz_port #(.AW(AW)) u_port (
        .clk(clk), .rst_n(rst_n),
        .issue(issue), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .cpl(cpl), .rdata(rdata)
    );

endmodule

// File: rtl/ramsz_chk.sv
// Protocol and result checker for ramsz_top, attached with bind.
module ramsz_chk #(
    parameter int AW       = 20,
    parameter int MAX_SIZE = 1 << 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata,
    input logic          mem_ack,
    input logic          done,
    input logic          no_ram,
    input logic [AW:0]   size
);

    localparam logic [AW:0] LIMIT = (AW+1)'(MAX_SIZE);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req); // R9
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
    AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req); // R9
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> {1'b0, mem_addr} < LIMIT); // R3
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R8
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(size) && $stable(no_ram)); // R8
    AST_NORAM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && no_ram |-> size == '0); // R2
    AST_SIZE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        done && !no_ram |-> $countones(size) == 1 && size <= LIMIT); // R5

endmodule

bind ramsz_top ramsz_chk #(.AW(AW), .MAX_SIZE(MAX_SIZE)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .done(done), .no_ram(no_ram), .size(size)
);

// File: tb/ramsz_top_bench.sv
module ramsz_top_bench;

    localparam int AW  = 12;
    localparam int MAX = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mem_req, mem_we, mem_ack, done, no_ram;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic [AW:0]   size;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // emulated memory configuration
    int cfg_n   = 0;     // 0 = absent, else power-of-two wrap size
    int cfg_lim = MAX;   // addresses at or above answer 0xFF, writes lost
    int cfg_lat = 1;

    logic [7:0] mem  [0:MAX-1];
    logic [7:0] refm [0:MAX-1];
    logic [7:0] snap [0:MAX-1];
    logic [20:0] expq [$];   // {we, addr[11:0], wdata}

    always #10 clk = ~clk;   // 50 MHz

    ramsz_top #(.AW(AW), .MAX_SIZE(MAX)) u_ramsz_top (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .no_ram(no_ram), .size(size)
    );

    function automatic int map_addr(input int a);
        if (cfg_n == 0 || a >= cfg_lim) return -1;
        return a & (cfg_n - 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory responder
    int cnt = 0;
    initial mem_ack = 1'b0;
    initial mem_rdata = 8'h00;
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            if (cnt >= cfg_lat) begin
                int idx;
                idx = map_addr(int'(mem_addr));
                mem_ack <= 1'b1;
                cnt <= 0;
                if (mem_we) begin
                    if (idx >= 0) mem[idx] <= mem_wdata;
                end else begin
                    mem_rdata <= (idx >= 0) ? mem[idx] : 8'hFF;
                end
            end else cnt <= cnt + 1;
        end else mem_ack <= 1'b0;
    end

    // per-cycle comparison against the reference transaction queue
    bit prev_acc = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_acc) check(!mem_req, "R9 gap after ack", int'(mem_req), 0);
            if (mem_req && mem_ack) begin
                logic [20:0] e;
                if (expq.size() == 0) begin
                    check(1'b0, "R10 unexpected transaction", int'(mem_addr), -1);
                end else begin
                    e = expq.pop_front();
                    check(mem_we == e[20] && mem_addr == e[19:8] && (!e[20] || mem_wdata == e[7:0]),
                          "R4 transaction (R1 R3 R6 order)",
                          {mem_we, mem_addr, mem_wdata}, e);
                end
                prev_acc = 1;
            end else prev_acc = 0;
        end
    end

    // reference model: behavioural probe on its own copy of memory
    task automatic r_rd(input int a, output logic [7:0] v);
        int idx;
        idx = map_addr(a);
        v = (idx >= 0) ? refm[idx] : 8'hFF;
        expq.push_back({1'b0, 12'(a), 8'h00});
    endtask

    task automatic r_wr(input int a, input logic [7:0] d);
        int idx;
        idx = map_addr(a);
        if (idx >= 0) refm[idx] = d;
        expq.push_back({1'b1, 12'(a), d});
    endtask

    task automatic ref_run(output int esize, output bit enoram);
        logic [7:0] b0, b1, v, s;
        expq.delete();
        esize = 0; enoram = 0;
        r_rd(0, b0);
        r_rd(1, b1);
        r_wr(0, ~b0);
        r_rd(0, v);
        if (v != ~b0) enoram = 1;
        else begin
            r_wr(0, 8'h55);
            esize = MAX;
            for (int p = 1; p < MAX; p = p * 2) begin
                r_rd(p, s);
                r_wr(p, 8'hAA);
                r_rd(0, v);
                if (v != 8'h55) begin esize = p; break; end
                r_rd(p, v);
                if (v != 8'hAA) begin esize = p; break; end
                r_wr(p, s);
            end
        end
        r_wr(1, b1);
        r_wr(0, b0);
    endtask

    task automatic scenario(input int n, input int lim, input int lat, input bit poke, input int seed);
        int esize;
        bit enoram;
        bit same;
        cfg_n = n; cfg_lim = lim; cfg_lat = lat;
        for (int i = 0; i < MAX; i++) begin
            mem[i]  = 8'((i * 37 + seed * 11 + 3) & 255);
            refm[i] = mem[i];
            snap[i] = mem[i];
        end
        ref_run(esize, enoram);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            start = 1'b1;                      // R10: pulse while busy
            @(negedge clk) start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(no_ram == enoram, "R2 no_ram flag", int'(no_ram), int'(enoram));
        check(int'(size) == esize, "R5 R7 detected size", int'(size), esize);
        check(expq.size() == 0, "R10 all transactions issued", expq.size(), 0);
        same = 1;
        for (int i = 0; i < MAX; i++) if (mem[i] !== snap[i]) same = 0;
        check(same, "R8 contents restored", int'(same), 1);
        repeat (3) @(negedge clk);
        check(done && !mem_req, "R8 done held", int'(done), 1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!mem_req && !done && !no_ram && size == 0, "R11 reset state",
              {mem_req, done, no_ram}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req && !done && !no_ram && size == 0, "R11 after reset",
              {mem_req, done, no_ram}, 0);
        scenario(0,    MAX, 1, 0, 1);  // R2 absent
        scenario(1,    MAX, 2, 0, 2);  // R5 wrap at 1
        scenario(2,    MAX, 0, 0, 3);  // R5 wrap at 2
        scenario(256,  MAX, 3, 0, 4);  // R5 wrap, slow ack
        scenario(4096, MAX, 1, 0, 5);  // R7 full
        scenario(4096, 512, 1, 0, 6);  // R5 probe read fails
        scenario(64,   MAX, 0, 1, 7);  // R10 start while busy
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule